// File: doc/BRIEF.md
# Shift-and-Add Sequential Multiplier

This block forms the full-width unsigned product of two `WIDTH`-bit operands by repeated conditional addition and right shifting. It keeps a high-half accumulator with a one-bit carry stage above it and a low-half register that starts out holding the multiplier. After each step the low half holds fewer multiplier bits and more product bits. A down counter, loaded with `WIDTH` when a run begins, tracks how many steps remain. A zero flag on that counter ends the run.

A four-state controller sequences the work. Its next state comes from one multiplexer per state bit, selected by the present state. A decoder turns the state into one line per state. The states, in encoding order, are:

- `ST_IDLE` (00): waits for `start`.
- `ST_INIT` (01): clears the accumulator and carry and loads the counter.
- `ST_ADD` (10): counts down, and adds the multiplicand when the low bit of the low half is 1.
- `ST_SHIFT` (11): shifts carry, accumulator and low half right by one.

The transitions are:

- `ST_IDLE` goes to `ST_INIT` when `start` is 1, and holds otherwise.
- `ST_INIT` always goes to `ST_ADD`.
- `ST_ADD` always goes to `ST_SHIFT`.
- `ST_SHIFT` returns to `ST_ADD` while the counter is non-zero, and to `ST_IDLE` once it is zero.

A user pulses `start` with the operands valid while `idle` is high. The user then waits for `idle` to return, and reads `product`. The operands are captured when the start is accepted, so they need not stay stable during the run.

Top module: `shift_add_mult`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the block into `ST_IDLE`, so that `idle` is 1 and `product` is 0 after that edge, even in the middle of a run.
- R2: While idle with `start` low, the block stays idle and `product` does not change.
- R3: When `start` is 1 at an edge while idle, the operands are captured and `idle` is 0 after that edge.
- R4: When a run ends, `product` equals the unsigned product `mcand * mplier` of the captured operands, across all `2*WIDTH` bits. `product[2*WIDTH-1:WIDTH]` is the high half and `product[WIDTH-1:0]` is the low half.
- R5: After a run, the product stays on `product` while idle and `start` is low, whatever the operand inputs do.
- R6: During a run, `start` and changes on `mcand` and `mplier` have no effect on the result or on the run length.
- R7: Boundary operands give exact results. These include zero operands, and the all-ones by all-ones case, whose addition carries out of the accumulator.
- R8: `idle` returns to 1 exactly `2*WIDTH+2` clock edges after the edge that accepted `start`, counting that edge. The run is one init step followed by `WIDTH` add/shift pairs, and it leaves the shift state for idle when the counter reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiplication (accepted only while idle) |
| mcand | input | WIDTH | Multiplicand operand |
| mplier | input | WIDTH | Multiplier operand |
| product | output | 2*WIDTH | High half from the accumulator, low half from the shifted multiplier register |
| idle | output | 1 | 1 while the controller is in its waiting state |

## Verification
A wrong state code or a wrong multiplexer input bends the sequence. That shows up at the ports as `idle` returning on the wrong edge, or never, so a latency count against `2*WIDTH+2` catches it within one run. A fault in the add or shift data path, such as a lost carry, a wrong fill bit or a skipped add, appears only in `product` when `idle` rises. The all-ones operands and the exhaustive sweep of every 4-bit pair expose such a fault on the first run that needs the faulty path.

// File: rtl/shift_add_mult_pkg.sv
package shift_add_mult_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_INIT  = 2'b01,
        ST_ADD   = 2'b10,
        ST_SHIFT = 2'b11
    } mstate_e;

    localparam int NUM_STATES = 4;

    typedef struct packed {
        logic load_ops;
        logic init;
        logic count_dn;
        logic add_en;
        logic shift;
    } mctrl_t;

endpackage

// File: rtl/mult_ctrl.sv
module mult_ctrl
    import shift_add_mult_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   zero,
    input  logic   q_lsb,
    output mctrl_t ctrl,
    output logic   idle,
    output logic [1:0] st_bits
);

    localparam int SB = $clog2(NUM_STATES);

    mstate_e        state_q;
    logic [SB-1:0]  nxt_bits;
    logic [NUM_STATES-1:0] mux_in [SB];
    logic [NUM_STATES-1:0] dec;

    // Multiplexer inputs, indexed by present state code (3..0).
    always_comb begin
        mux_in[1] = {~zero, 1'b1, 1'b1, 1'b0};
        mux_in[0] = {1'b0,  1'b1, 1'b0, start};
    end

    generate
        for (genvar g = 0; g < SB; g++) begin : g_nxt_mux
            assign nxt_bits[g] = mux_in[g][state_q];
        end
    endgenerate

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= mstate_e'(nxt_bits);
        end
    end

    // State decoder.
    generate
        for (genvar s = 0; s < NUM_STATES; s++) begin : g_dec
            assign dec[s] = (state_q == mstate_e'(s));
        end
    endgenerate

    // Output process.
    always_comb begin
        ctrl = '0;
        unique case (1'b1)
            dec[ST_IDLE]:  ctrl.load_ops = start;
            dec[ST_INIT]:  ctrl.init     = 1'b1;
            dec[ST_ADD]: begin
                ctrl.count_dn = 1'b1;
                ctrl.add_en   = q_lsb;
            end
            dec[ST_SHIFT]: ctrl.shift    = 1'b1;
            default:       ctrl          = '0;
        endcase
    end

    assign idle    = dec[ST_IDLE];
    assign st_bits = state_q;

endmodule

// File: rtl/mult_counter.sv
module mult_counter #(
    parameter int WIDTH = 4,
    localparam int PW   = $clog2(WIDTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          dec_en,
    output logic [PW-1:0] cnt,
    output logic          zero
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= PW'(WIDTH);
        end else if (dec_en) begin
            cnt <= cnt - PW'(1);
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/mult_datapath.sv
module mult_datapath
    import shift_add_mult_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  mctrl_t             ctrl,
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    output logic               q_lsb,
    output logic [2*WIDTH-1:0] product
);

    logic [WIDTH-1:0] acc_q;
    logic [WIDTH-1:0] low_q;
    logic [WIDTH-1:0] mcand_q;
    logic             carry_q;
    logic [WIDTH:0]   sum;

    assign sum = {1'b0, acc_q} + {1'b0, mcand_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            low_q   <= '0;
            mcand_q <= '0;
            carry_q <= 1'b0;
        end else if (ctrl.load_ops) begin
            mcand_q <= mcand;
            low_q   <= mplier;
        end else if (ctrl.init) begin
            acc_q   <= '0;
            carry_q <= 1'b0;
        end else if (ctrl.add_en) begin
            acc_q   <= sum[WIDTH-1:0];
            carry_q <= sum[WIDTH];
        end else if (ctrl.shift) begin
            acc_q   <= {carry_q, acc_q[WIDTH-1:1]};
            low_q   <= {acc_q[0], low_q[WIDTH-1:1]};
            carry_q <= 1'b0;
        end
    end

    assign q_lsb   = low_q[0];
    assign product = {acc_q, low_q};

endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult
    import shift_add_mult_pkg::*;
#(
    parameter int WIDTH = 4,
    localparam int PW   = $clog2(WIDTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    output logic [2*WIDTH-1:0] product,
    output logic               idle
);

    mctrl_t        ctrl;
    logic          zero;
    logic          q_lsb;
    logic [PW-1:0] p_cnt;
    logic [1:0]    st_bits;

    mult_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .zero    (zero),
        .q_lsb   (q_lsb),
        .ctrl    (ctrl),
        .idle    (idle),
        .st_bits (st_bits)
    );

    mult_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .load   (ctrl.init),
        .dec_en (ctrl.count_dn),
        .cnt    (p_cnt),
        .zero   (zero)
    );

    mult_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk     (clk),
        .rst     (rst),
        .ctrl    (ctrl),
        .mcand   (mcand),
        .mplier  (mplier),
        .q_lsb   (q_lsb),
        .product (product)
    );

endmodule

// File: rtl/shift_add_mult_chk.sv
module shift_add_mult_chk #(
    parameter int WIDTH = 4,
    localparam int PW   = $clog2(WIDTH + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic [WIDTH-1:0]   mcand,
    input logic [WIDTH-1:0]   mplier,
    input logic [2*WIDTH-1:0] product,
    input logic               idle,
    input logic [PW-1:0]      p_cnt,
    input logic [1:0]         st_bits
);

    logic [2*WIDTH-1:0] exp_q;
    logic               seen_q;
    logic [31:0]        busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_q  <= '0;
            seen_q <= 1'b0;
            busy_q <= '0;
        end else begin
            if (idle && start) begin
                exp_q  <= {{WIDTH{1'b0}}, mcand} * {{WIDTH{1'b0}}, mplier};
                seen_q <= 1'b1;
            end
            busy_q <= idle ? 32'd0 : busy_q + 32'd1;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk) rst |=> (idle && product == '0));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (idle && !start) |=> (idle && $stable(product)));

    p_leave_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (idle && start) |=> !idle);

    p_result_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(idle) && seen_q) |-> (product == exp_q));

    p_latency_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(idle) && seen_q) |-> (busy_q == 32'(2 * WIDTH + 1)));

    p_end_on_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (st_bits == 2'b11 && p_cnt == '0) |=> idle);

    p_cnt_range_r8: assert property (@(posedge clk) disable iff (rst)
        p_cnt <= PW'(WIDTH));

endmodule

bind shift_add_mult shift_add_mult_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .mcand   (mcand),
    .mplier  (mplier),
    .product (product),
    .idle    (idle),
    .p_cnt   (p_cnt),
    .st_bits (st_bits)
);

// File: tb/sim_shift_add_mult.sv
module sim_shift_add_mult;

    localparam int W   = 4;
    localparam int LAT = 2 * W + 2;

    logic           clk = 1'b0;
    logic           rst;
    logic           start;
    logic [W-1:0]   mcand;
    logic [W-1:0]   mplier;
    logic [2*W-1:0] product;
    logic           idle;

    int n_chk  = 0;
    int n_fail = 0;

    // {multiplicand, multiplier, expected product}
    localparam logic [4*W-1:0] VEC [8] = '{
        {4'd0,  4'd0,  8'd0},
        {4'd15, 4'd15, 8'd225},
        {4'd1,  4'd15, 8'd15},
        {4'd15, 4'd1,  8'd15},
        {4'd8,  4'd8,  8'd64},
        {4'd7,  4'd9,  8'd63},
        {4'd10, 4'd5,  8'd50},
        {4'd12, 4'd13, 8'd156}
    };

    always #5 clk = ~clk;

    shift_add_mult #(.WIDTH(W)) u0 (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .mcand   (mcand),
        .mplier  (mplier),
        .product (product),
        .idle    (idle)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Launch a run and wait for idle; returns product and edge count.
    task automatic run_mult(input logic [W-1:0] a, input logic [W-1:0] b,
                            input bit poke, output logic [2*W-1:0] p, output int lat);
        @(negedge clk);
        mcand = a; mplier = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        check(idle == 1'b0, "R3", int'(idle), 0);
        while (!idle && lat < 100) begin
            if (poke && lat == 3) begin
                start = 1'b1; mcand = ~a; mplier = ~b;
            end else if (poke) begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        p = product;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [2*W-1:0] p;
        int lat;
        rst = 1'b1; start = 1'b0; mcand = '0; mplier = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(idle == 1'b1, "R1", int'(idle), 1);
        check(product == '0, "R1", int'(product), 0);
        rst = 1'b0;

        // R2: idle holds while start low
        repeat (4) @(negedge clk);
        check(idle == 1'b1 && product == '0, "R2", int'(product), 0);

        // Table walk (R4, R7, R8)
        for (int i = 0; i < 8; i++) begin
            run_mult(VEC[i][4*W-1:3*W], VEC[i][3*W-1:2*W], 1'b0, p, lat);
            check(p == VEC[i][2*W-1:0], "R7", int'(p), int'(VEC[i][2*W-1:0]));
            check(lat == LAT, "R8", lat, LAT);
        end

        // Exhaustive products (R4)
        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                run_mult(W'(a), W'(b), 1'b0, p, lat);
                check(int'(p) == a * b, "R4", int'(p), a * b);
            end
        end

        // R5: result held while idle and operands wiggle
        run_mult(4'd11, 4'd14, 1'b0, p, lat);
        for (int k = 0; k < 5; k++) begin
            mcand = W'(k * 3); mplier = W'(k + 7);
            @(negedge clk);
        end
        check(product == 8'd154 && idle, "R5", int'(product), 154);

        // R6: start and operand changes during a run are ignored
        run_mult(4'd13, 4'd11, 1'b1, p, lat);
        check(p == 8'd143, "R6", int'(p), 143);
        check(lat == LAT, "R6", lat, LAT);

        // R1: reset in the middle of a run
        @(negedge clk);
        mcand = 4'd9; mplier = 4'd9; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(idle == 1'b1, "R1", int'(idle), 1);
        check(product == '0, "R1", int'(product), 0);

        // R8: a clean run after the aborted one
        run_mult(4'd6, 4'd7, 1'b0, p, lat);
        check(p == 8'd42, "R4", int'(p), 42);
        check(lat == LAT, "R8", lat, LAT);

        finish_run();
    end

endmodule